// File: doc/BRIEF.md
# SPI Flash Read Sequencer

This engine pulls a contiguous range of bytes out of a serial NOR flash through a plain SPI link (clock idles low, data sampled on the rising edge). A request is a 24-bit start offset and a byte count, accepted by a start pulse while the engine is idle. The engine drops chip select and shifts out a four-byte header: the read opcode, then the offset high byte first. It then clocks in as many data bytes as requested and releases chip select.

Each received byte appears on a valid/ready stream. A consumer that holds ready low stops the serial clock between bytes, so a slow sink never loses data. An abort input ends a transfer at any point and returns chip select high. A busy flag covers the whole request. A one-cycle done pulse marks the release of chip select. A gap timer keeps chip select high for a minimum time between transfers.

Top module: `spi_flash_reader`

## Requirements
- R1: The first byte shifted out after chip select falls is 0x03, sent MSB first; SCLK idles low and MOSI is set up before each rising edge.
- R2: Three address bytes follow the opcode: offset bits 23:16, then 15:8, then 7:0, each MSB first.
- R3: Exactly `count_i` data bytes are presented on `data_o`, each assembled MSB first from MISO bits sampled on SCLK rising edges, in the order received.
- R4: During the data phase MOSI is held at 1.
- R5: A byte count of zero sends only the four header bytes, releases chip select and presents no data.
- R6: Chip select falls once per transaction and stays low through header and data, with no release in between.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o` and `data_o` hold and SCLK does not toggle; no byte is dropped.
- R8: `busy_o` rises the cycle after an accepted start and falls in the same cycle chip select rises; `done_o` is high for exactly the one cycle after chip select rises.
- R9: Chip select stays high for at least two SCLK periods (4*HALF_DIV clock cycles) between consecutive transactions.
- R10: An `abort_i` pulse during a transfer raises chip select and clears `busy_o` and `valid_o` in the next cycle; `done_o` follows one cycle later.
- R11: `start_i` is ignored while `busy_o` is high; the running transfer is unaffected and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken when idle |
| abort_i | input | 1 | Ends the running transfer |
| offset_i | input | 24 | Flash start offset |
| count_i | input | CNT_W | Number of data bytes to read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after chip select release |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | `data_o` holds a byte |
| ready_i | input | 1 | Consumer accepts the byte |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
A start pulse sampled at one edge raises busy after that edge. Chip select falls one edge later when no gap is pending, and the bench checks both on the following falling clock edges. Chip select rises and busy falls on the same edge. Done follows on the next edge, and an abort sampled at one edge shows released outputs after it, so the bench checks one and two falling edges later. Stream bytes are taken on falling edges where valid and ready are both high, which is the edge before the design retires the byte. A flash model answers from the address it captured, so any mistake in header order shows up as a data mismatch.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam logic [7:0] READ_OP = 8'h03;
  localparam logic [7:0] IDLE_TX = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HDR,
    ST_DATA,
    ST_HOLD
  } rd_state_e;
endpackage

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       active_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;
  logic          sclk_q, act_q, done_q;
  logic          tick;

  assign tick = act_q && (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        act_q  <= 1'b0;
        sclk_q <= 1'b0;
        div_q  <= '0;
      end else if (go_i && !act_q) begin
        act_q  <= 1'b1;
        tx_q   <= tx_i;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (act_q) begin
        if (tick) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            rx_q <= {rx_q[6:0], miso_i};
          end else begin
            tx_q  <= {tx_q[6:0], 1'b1};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign mosi_o   = act_q ? tx_q[7] : 1'b1;
  assign active_o = act_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;

  // R1
  sclk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> ($past(act_q) || !sclk_o));
endmodule

// File: rtl/spi_rd_gap.sv
module spi_rd_gap #(
  parameter int unsigned GAP_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= CW'(GAP_CYC);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

  // R9
  gap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !idle_o);
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_SCLK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [23:0]       offset_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned GAP_CYC = GAP_SCLK * 2 * HALF_DIV;

  rd_state_e         st_q;
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0]  rem_q;
  logic [1:0]        hdr_q;
  logic [7:0]        tx_q, data_q;
  logic              cs_n_q, cs_prev_q, busy_q, valid_q, go_q, done_q;
  logic              sh_active, sh_done, gap_idle, release_w, abort_w;
  logic [7:0]        sh_rx;
  logic [7:0]        next_addr;

  assign abort_w = abort_i && (st_q != ST_IDLE);

  always_comb begin
    case (hdr_q)
      2'd0:    next_addr = off_q[23:16];
      2'd1:    next_addr = off_q[15:8];
      default: next_addr = off_q[7:0];
    endcase
  end

  assign release_w = !cs_n_q && (abort_i ||
                     (st_q == ST_HDR && sh_done && hdr_q == 2'd3 && rem_q == '0) ||
                     (st_q == ST_HOLD && ready_i && rem_q == '0));

  spi_rd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (abort_w),
    .go_i     (go_q),
    .tx_i     (tx_q),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .active_o (sh_active),
    .done_o   (sh_done),
    .rx_o     (sh_rx)
  );

  spi_rd_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (release_w),
    .idle_o (gap_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      off_q     <= '0;
      rem_q     <= '0;
      hdr_q     <= '0;
      tx_q      <= IDLE_TX;
      data_q    <= '0;
      cs_n_q    <= 1'b1;
      cs_prev_q <= 1'b1;
      busy_q    <= 1'b0;
      valid_q   <= 1'b0;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      go_q      <= 1'b0;
      cs_prev_q <= cs_n_q;
      done_q    <= cs_n_q && !cs_prev_q;
      if (abort_w) begin
        st_q    <= ST_IDLE;
        cs_n_q  <= 1'b1;
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            off_q  <= offset_i;
            rem_q  <= count_i;
            busy_q <= 1'b1;
            st_q   <= ST_SETUP;
          end
          ST_SETUP: if (gap_idle) begin
            cs_n_q <= 1'b0;
            go_q   <= 1'b1;
            tx_q   <= READ_OP;
            hdr_q  <= '0;
            st_q   <= ST_HDR;
          end
          ST_HDR: if (sh_done) begin
            if (hdr_q == 2'd3) begin
              if (rem_q == '0) begin
                cs_n_q <= 1'b1;
                busy_q <= 1'b0;
                st_q   <= ST_IDLE;
              end else begin
                go_q <= 1'b1;
                tx_q <= IDLE_TX;
                st_q <= ST_DATA;
              end
            end else begin
              hdr_q <= hdr_q + 2'd1;
              go_q  <= 1'b1;
              tx_q  <= next_addr;
            end
          end
          ST_DATA: if (sh_done) begin
            data_q  <= sh_rx;
            valid_q <= 1'b1;
            rem_q   <= rem_q - 1'b1;
            st_q    <= ST_HOLD;
          end
          ST_HOLD: if (ready_i) begin
            valid_q <= 1'b0;
            if (rem_q == '0) begin
              cs_n_q <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              go_q <= 1'b1;
              tx_q <= IDLE_TX;
              st_q <= ST_DATA;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cs_no   = cs_n_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R6
  cs_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_active |-> !cs_no);
  // R8
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  // R8
  done_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cs_no) && !$past(cs_no, 2)));
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !abort_i) |=> (valid_o && $stable(data_o) && $stable(sclk_o)));
  // R9
  gap_respected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(gap_idle));
  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(off_q));
endmodule

// File: tb/spi_flash_reader_test.sv
module spi_flash_reader_test;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned HALF  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, ready = 1'b1, miso = 1'b0;
  logic [23:0] offset = '0;
  logic [CNT_W-1:0] count = '0;
  logic busy, done, valid, sclk, cs_n, mosi;
  logic [7:0] data;

  always #4 clk = ~clk;

  spi_flash_reader #(.CNT_W(CNT_W), .HALF_DIV(HALF), .GAP_SCLK(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .offset_i(offset), .count_i(count), .busy_o(busy), .done_o(done),
    .data_o(data), .valid_o(valid), .ready_i(ready), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  int nchk = 0, nfail = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a, input int k);
    return (a[7:0] ^ 8'h5A) + 8'(k * 37);
  endfunction

  // flash model
  int sbit = 0, mosi_bad = 0, cs_falls = 0;
  logic [31:0] hdr_cap = '0;
  always @(negedge cs_n) begin
    sbit = 0; miso = 1'b0; cs_falls++;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (sbit < 32) hdr_cap = {hdr_cap[30:0], mosi};
    else if (!mosi) mosi_bad++;
    sbit++;
  end
  always @(negedge sclk) if (!cs_n) begin
    if (sbit < 32) miso = sbit[0];
    else begin
      logic [7:0] t;
      t = fbyte(hdr_cap[23:0], (sbit - 32) / 8);
      miso = t[7 - ((sbit - 32) % 8)];
    end
  end

  // stream sink and monitors
  logic [7:0] got [64];
  int ngot = 0, hold_bad = 0, done_bad = 0, gap_len = 0, last_gap = 0;
  bit stall_en = 1'b0, prev_stall = 1'b0, rose_prev = 1'b0;
  logic prev_sclk = 1'b0, cs_prev = 1'b1;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    cyc++;
    ready = stall_en ? (cyc % 5 == 0) : 1'b1;
    if (rst_n) begin
      if (prev_stall && !abort && (!valid || sclk !== prev_sclk || data !== prev_data)) hold_bad++;
      if (valid && ready) begin
        if (ngot < 64) got[ngot] = data;
        ngot++;
      end
      prev_stall = valid && !ready;
      prev_sclk = sclk; prev_data = data;
      if (done !== rose_prev) done_bad++;
      rose_prev = cs_n && !cs_prev;
      if (rose_prev && busy) done_bad++;
      if (cs_n) gap_len++;
      else if (cs_prev) begin last_gap = gap_len; gap_len = 0; end
      cs_prev = cs_n;
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(n < 20000, "R8 done timeout", n, 0);
  endtask

  task automatic issue(input logic [23:0] off, input int cnt);
    @(negedge clk);
    offset = off; count = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic verify(input logic [23:0] off, input int cnt, input string tag);
    int bad = 0;
    check(hdr_cap == {8'h03, off}, {tag, " R1 R2 header"}, hdr_cap, {8'h03, off});
    check(ngot == cnt, {tag, " R3 count"}, ngot, cnt);
    for (int k = 0; k < cnt && k < 64; k++) if (got[k] !== fbyte(off, k)) bad++;
    check(bad == 0, {tag, " R3 data"}, bad, 0);
    check(mosi_bad == 0, {tag, " R4 mosi"}, mosi_bad, 0);
    check(cs_falls == 1, {tag, " R6 cs window"}, cs_falls, 1);
    check(hold_bad == 0, {tag, " R7 hold"}, hold_bad, 0);
    check(done_bad == 0, {tag, " R8 done"}, done_bad, 0);
  endtask

  task automatic clear_stats();
    ngot = 0; mosi_bad = 0; cs_falls = 0; hold_bad = 0; done_bad = 0;
  endtask

  task automatic run_read(input logic [23:0] off, input int cnt, input bit stall, input string tag);
    clear_stats(); stall_en = stall;
    issue(off, cnt);
    check(busy == 1'b1, {tag, " R8 busy rise"}, busy, 1);
    wait_done();
    verify(off, cnt, tag);
  endtask

  task automatic t_reset();
    check(cs_n === 1'b1 && sclk === 1'b0, "R1 reset lines", {cs_n, sclk}, 2'b10);
    check(busy === 1'b0 && valid === 1'b0 && done === 1'b0, "R8 reset flags",
          {busy, valid, done}, 0);
  endtask

  task automatic t_basic();
    clear_stats(); stall_en = 1'b0;
    repeat (12) @(negedge clk);
    issue(24'h123456, 5);
    check(busy && cs_n, "R8 busy before cs", {busy, cs_n}, 2'b11);
    @(negedge clk);
    check(!cs_n, "R6 cs fall", cs_n, 0);
    wait_done();
    verify(24'h123456, 5, "basic");
  endtask

  task automatic t_b2b();
    run_read(24'h00A0F3, 3, 1'b0, "b2b1");
    clear_stats();
    issue(24'hFEDCBA, 4);
    wait_done();
    verify(24'hFEDCBA, 4, "b2b2");
    check(last_gap >= 4 * HALF, "R9 gap", last_gap, 4 * HALF);
  endtask

  task automatic t_start_ignore();
    clear_stats(); stall_en = 1'b0;
    issue(24'h5A5A00, 6);
    repeat (50) @(negedge clk);
    offset = 24'h000001; count = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    verify(24'h5A5A00, 6, "ignore R11");
    repeat (20) @(negedge clk);
    check(!busy && cs_n, "R11 no second transfer", {busy, cs_n}, 2'b01);
  endtask

  task automatic t_abort();
    int n = 0;
    clear_stats(); stall_en = 1'b0;
    issue(24'h0C0FFE, 10);
    while (ngot < 2 && n < 5000) begin @(negedge clk); n++; end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(cs_n && !busy && !valid, "R10 release", {cs_n, busy, valid}, 3'b100);
    check(!done, "R10 done not early", done, 0);
    @(negedge clk);
    check(done, "R10 done pulse", done, 1);
    repeat (20) @(negedge clk);
    run_read(24'h0A0B0C, 2, 1'b0, "after abort R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    run_read(24'hABCDEF, 0, 1'b0, "zero R5");
    run_read(24'h00FF01, 12, 1'b1, "stall R7");
    t_b2b();
    t_start_ignore();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule